// File: doc/BRIEF.md
# ADC Sample Format Normalizer

This block sits between a parallel analog-to-digital converter interface and the capture logic behind it. Converters of 12, 14, 16 or 18 bits may be attached, and they deliver two's complement samples placed in the low bits of an 18-bit input bus. A two-bit width code selects the attached converter's width at run time. Every sample is turned into an unsigned offset binary word by inverting the sign bit at the selected width. The word stays right-justified, and every bit above the selected width is cleared, so later stages see one common format whatever the converter.

Samples are qualified by a data-ready strobe in the converter's clock domain. The width code is sampled on the same edge as the sample it applies to. The converted word and a valid strobe appear one clock later. Between strobes the output word holds its last value.

Top module: `adc_fmt_norm`

## Requirements
- R1: During a cycle in which `rst_n` is sampled low, the block clears its outputs, so on the following cycle `valid_o` is 0 and `data_o` is 0.
- R2: The width code selects the converter width: code 2'b00 is 18 bits, 2'b01 is 16 bits, 2'b10 is 14 bits and 2'b11 is 12 bits.
- R3: The bit at position (width-1) of the sample is inverted, which turns two's complement into offset binary. For 12 bits, 0x800 becomes 0x000, 0x7FF becomes 0xFFF and 0x000 becomes 0x800. For 18 bits, 0x20000 becomes 0x00000 and 0x1FFFF becomes 0x3FFFF.
- R4: The output is right-justified. Output bits at positions equal to or above the selected width are 0, whatever the input carries in those positions.
- R5: `valid_o` is high in exactly the cycles that follow a rising clock edge at which `drdy_i` was high, which gives one cycle of latency.
- R6: While no strobe is taken, `data_o` keeps its previous value, even if `sample_i` or `width_sel_i` change.
- R7: The width code is captured together with each sample. Back-to-back samples taken with different codes are each converted using their own code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter data-ready clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drdy_i | input | 1 | Sample qualifier strobe |
| width_sel_i | input | 2 | Converter width code (see R2) |
| sample_i | input | 18 | Raw two's complement sample, LSB-aligned |
| valid_o | output | 1 | Converted word valid, one cycle after the strobe |
| data_o | output | 18 | Offset binary word, zero above the selected width |

## Verification
The bench targets the full-scale and mid-scale codes at both extremes of width. A sign flip placed at a fixed position would give wrong values for 0x800 at 12 bits and for 0x20000 at 18 bits. Samples whose unused upper bits are set expose a design that leaks them through instead of clearing them. Back-to-back strobes with a different code on each cycle catch a design that applies one cycle's code to the neighbouring sample. Idle cycles with the inputs changing catch an output register that reloads without a strobe.

// File: rtl/adc_fmt_pkg.sv
// Package: shared sizing and width-code decoding for the sample normalizer.
// Assumes each step of the width code removes a fixed number of bits from
// the widest supported converter.
package adc_fmt_pkg;
    localparam int unsigned MAX_W  = 18;  // widest converter / output word
    localparam int unsigned CODE_W = 2;   // width select code bits
    localparam int unsigned STEP_W = 2;   // bits removed per code step

    // Return the converter width that a width code selects.
    function automatic int unsigned width_of(input logic [CODE_W-1:0] code,
                                             input int unsigned max_w,
                                             input int unsigned step_w);
        return max_w - step_w * int'(code);
    endfunction
endpackage

// File: rtl/adc_fmt_width_dec.sv
// Module: adc_fmt_width_dec
// Turns a width code into two per-bit vectors. The keep mask marks the
// valid sample bits, and the sign select marks the single bit to invert.
// Assumes every code selects a width between 1 and MAX_W.
module adc_fmt_width_dec #(
    parameter int unsigned MAX_W  = adc_fmt_pkg::MAX_W,
    parameter int unsigned CODE_W = adc_fmt_pkg::CODE_W,
    parameter int unsigned STEP_W = adc_fmt_pkg::STEP_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [MAX_W-1:0]  keep_o,
    output logic [MAX_W-1:0]  sign_o
);
    int unsigned width;

    // Decode the code into a bit count.
    always_comb begin
        width = adc_fmt_pkg::width_of(code_i, MAX_W, STEP_W);
    end

    for (genvar b = 0; b < MAX_W; b++) begin : g_bit
        // Mark bit b as kept, or as the sign position, for the decoded width.
        always_comb begin
            keep_o[b] = (32'(b) < width);
            sign_o[b] = (32'(b) == width - 32'd1);
        end
    end
endmodule

// File: rtl/adc_fmt_convert.sv
// Module: adc_fmt_convert
// Purely combinational conversion from a two's complement sample to an
// offset binary word. Bits outside the keep mask are cleared, and the bit
// under the sign select is inverted. Assumes the sign select is one-hot and
// lies inside the keep mask.
module adc_fmt_convert #(
    parameter int unsigned MAX_W = adc_fmt_pkg::MAX_W
) (
    input  logic [MAX_W-1:0] raw_i,
    input  logic [MAX_W-1:0] keep_i,
    input  logic [MAX_W-1:0] sign_i,
    output logic [MAX_W-1:0] conv_o
);
    for (genvar b = 0; b < MAX_W; b++) begin : g_bit
        // Mask, then flip the selected sign bit.
        always_comb begin
            conv_o[b] = (raw_i[b] & keep_i[b]) ^ sign_i[b];
        end
    end
endmodule

// File: rtl/adc_fmt_out_reg.sv
// Module: adc_fmt_out_reg
// Output stage. It loads the converted word when the strobe is high, holds
// the word otherwise, and delays the strobe by one cycle.
// Assumes a synchronous active-low reset.
module adc_fmt_out_reg #(
    parameter int unsigned MAX_W = adc_fmt_pkg::MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [MAX_W-1:0] word_i,
    output logic             valid_o,
    output logic [MAX_W-1:0] word_o
);
    // Register the strobe and capture the word on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                word_o <= word_i;
            end
        end
    end
endmodule

// File: rtl/adc_fmt_norm.sv
// Module: adc_fmt_norm (top)
// Normalizes LSB-aligned two's complement converter samples into
// right-justified offset binary words, with the width picked at run time.
// The width code is taken on the same edge as its sample, so a code change
// applies from the next strobed sample onward. Latency is one cycle.
module adc_fmt_norm #(
    parameter int unsigned MAX_W  = adc_fmt_pkg::MAX_W,
    parameter int unsigned CODE_W = adc_fmt_pkg::CODE_W,
    parameter int unsigned STEP_W = adc_fmt_pkg::STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drdy_i,
    input  logic [CODE_W-1:0] width_sel_i,
    input  logic [MAX_W-1:0]  sample_i,
    output logic              valid_o,
    output logic [MAX_W-1:0]  data_o
);
    logic [MAX_W-1:0] keep_mask;
    logic [MAX_W-1:0] sign_sel;
    logic [MAX_W-1:0] conv_word;

    adc_fmt_width_dec #(
        .MAX_W (MAX_W),
        .CODE_W(CODE_W),
        .STEP_W(STEP_W)
    ) u_dec (
        .code_i(width_sel_i),
        .keep_o(keep_mask),
        .sign_o(sign_sel)
    );

    adc_fmt_convert #(
        .MAX_W(MAX_W)
    ) u_conv (
        .raw_i (sample_i),
        .keep_i(keep_mask),
        .sign_i(sign_sel),
        .conv_o(conv_word)
    );

    adc_fmt_out_reg #(
        .MAX_W(MAX_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (drdy_i),
        .word_i (conv_word),
        .valid_o(valid_o),
        .word_o (data_o)
    );
endmodule

// File: rtl/adc_fmt_norm_chk.sv
// Module: adc_fmt_norm_chk
// Property checker bound to adc_fmt_norm. It relates the outputs to the
// inputs of the previous cycle. Assumes the default 18-bit configuration.
module adc_fmt_norm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        drdy_i,
    input logic [1:0]  width_sel_i,
    input logic [17:0] sample_i,
    input logic        valid_o,
    input logic [17:0] data_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!valid_o && data_o == 18'd0));

    // R5
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (valid_o == $past(drdy_i)));

    // R6
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(drdy_i)) |-> $stable(data_o));

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(drdy_i) && $past(width_sel_i) == 2'b11)
            |-> (data_o[17:12] == 6'd0));

    // R3
    sign_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(drdy_i) && $past(width_sel_i) == 2'b00)
            |-> (data_o[17] != $past(sample_i[17])));

    // R2
    width16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(drdy_i) && $past(width_sel_i) == 2'b01)
            |-> (data_o[17:16] == 2'd0 && data_o[15] != $past(sample_i[15])));
endmodule

bind adc_fmt_norm adc_fmt_norm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drdy_i     (drdy_i),
    .width_sel_i(width_sel_i),
    .sample_i   (sample_i),
    .valid_o    (valid_o),
    .data_o     (data_o)
);

// File: tb/adc_fmt_norm_bench.sv
// Scoreboard bench for adc_fmt_norm. The driver pushes expected words into
// a queue, and the monitor pops and compares them whenever valid_o is high.
module adc_fmt_norm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drdy_i = 1'b0;
    logic [1:0]  width_sel_i = 2'b00;
    logic [17:0] sample_i = '0;
    logic        valid_o;
    logic [17:0] data_o;

    int tests = 0;
    int fails = 0;
    logic [17:0] exp_q[$];
    string       tag_q[$];
    logic [17:0] last_word = '0;

    always #2 clk = ~clk;  // 250 MHz

    adc_fmt_norm u_adc_fmt_norm (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_i     (drdy_i),
        .width_sel_i(width_sel_i),
        .sample_i   (sample_i),
        .valid_o    (valid_o),
        .data_o     (data_o)
    );

    // Reference from the requirements: R2 widths, R3 flip, R4 zero fill.
    function automatic logic [17:0] model(input logic [1:0] code,
                                          input logic [17:0] s);
        int w;
        logic [17:0] m;
        case (code)
            2'b00: w = 18;
            2'b01: w = 16;
            2'b10: w = 14;
            default: w = 12;
        endcase
        m = 18'((32'd1 << w) - 1);
        return (s & m) ^ 18'(32'd1 << (w - 1));
    endfunction

    task automatic check(input bit ok, input string tag, input logic [17:0] act,
                         input logic [17:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one strobed sample per call, with the expected word queued.
    task automatic send(input logic [1:0] code, input logic [17:0] s,
                        input string tag);
        @(negedge clk);
        drdy_i      = 1'b1;
        width_sel_i = code;
        sample_i    = s;
        exp_q.push_back(model(code, s));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drdy_i = 1'b0;
        end
    endtask

    // Monitor: compare each valid word against the scoreboard (R5).
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected valid", data_o, 18'd0);
            end else begin
                logic [17:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(data_o === e, t, data_o, e);
                last_word = data_o;
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs cleared after reset
        check(valid_o === 1'b0, "R1 valid after reset", {17'd0, valid_o}, 18'd0);
        check(data_o === 18'd0, "R1 data after reset", data_o, 18'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: 12-bit corner codes
        send(2'b11, 18'h00800, "R3 12b neg full scale");
        send(2'b11, 18'h007FF, "R3 12b pos full scale");
        send(2'b11, 18'h00000, "R3 12b mid scale");
        // R3: 18-bit corner codes
        send(2'b00, 18'h20000, "R3 18b neg full scale");
        send(2'b00, 18'h1FFFF, "R3 18b pos full scale");
        // R2: 16- and 14-bit widths
        send(2'b01, 18'h08000, "R2 16b neg full scale");
        send(2'b10, 18'h01FFF, "R2 14b pos full scale");
        // R4: garbage in the unused upper bits
        send(2'b11, 18'h3F123, "R4 12b upper bits cleared");
        send(2'b01, 18'h38000, "R4 16b upper bits cleared");
        send(2'b10, 18'h3E000, "R4 14b upper bits cleared");
        // R7: the code changes on every back-to-back strobe
        send(2'b00, 18'h2A5A5, "R7 b2b code 00");
        send(2'b11, 18'h2A5A5, "R7 b2b code 11");
        send(2'b01, 18'h2A5A5, "R7 b2b code 01");
        send(2'b10, 18'h2A5A5, "R7 b2b code 10");
        idle(1);

        // R6: the output holds while the inputs change without a strobe
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            width_sel_i = 2'(i);
            sample_i    = 18'h15555 ^ 18'(i * 7);
            check(data_o === last_word, "R6 hold without strobe", data_o, last_word);
            check(valid_o === 1'b0, "R5 no valid without strobe", {17'd0, valid_o}, 18'd0);
        end
        check(last_word === model(2'b10, 18'h2A5A5), "R6 held word value",
              last_word, model(2'b10, 18'h2A5A5));

        // R7: a code change made while idle applies to the next sample
        width_sel_i = 2'b11;
        send(2'b00, 18'h00ABC, "R7 new code on next sample");
        idle(2);
        check(exp_q.size() == 0, "R5 scoreboard drained", 18'(exp_q.size()), 18'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule